// File: doc/BRIEF.md
# Selectable CPU Clock and Wait-State Generator

This block turns a crystal-rate clock into the processor clock waveform and stretches each bus cycle by a number of wait states. A strap input says which of two crystals is fitted (a low-rate part near 14.318 MHz or a double-rate part near 28.636 MHz). Two speed-select bits choose a nominal 4.77, 7.15 or 9.54 MHz processor clock. A fast-memory bit removes wait states from bus memory cycles. The block makes every clock period a whole number of crystal ticks and shapes the high time of each period.

Bus-cycle timing is counted in processor clock periods. When a cycle begins, the caller raises a start strobe and gives a two-bit type code. The block then drives `ready_o` low for the number of periods that the effective speed, the fast-memory bit and the cycle type call for. A new speed or strap setting is picked up only at the end of a processor clock period. If 9.54 MHz is requested with the low-rate crystal fitted, the block runs at 7.15 MHz.

Top module: `cpu_clk_waitgen`

## Requirements
- R1: While reset is asserted, and until the first period ends after it, `ready_o` is 1, `cpu_ce_o` is 0 and `cpu_clk_o` is 1.
- R2: With `xtal_slow_i`=1 (low-rate crystal): `spd_sel_i`=00 gives a period of 3 ticks with 1 tick high. `spd_sel_i`=01 gives 2 ticks with 1 tick high.
- R3: With `xtal_slow_i`=0 (double-rate crystal): `spd_sel_i`=00 gives 6 ticks with 2 high (4.77). `spd_sel_i`=01 gives 4 ticks with 1 high (7.15). `spd_sel_i[1]`=1 gives 3 ticks with 2 high (9.54).
- R4: With `xtal_slow_i`=1, any setting with `spd_sel_i[1]`=1 runs at 7.15 MHz: 2 ticks, 1 high.
- R5: I/O cycles (`cyc_type_i`=00) hold `ready_o` low for 1 period at 4.77, 4 periods at 7.15 and 6 periods at 9.54.
- R6: On-board memory cycles (`cyc_type_i`=01) never drop `ready_o`.
- R7: Bus memory cycles (`cyc_type_i`=10) take 0 waits at 4.77. At 7.15 they take 2 waits, or 0 with `fast_mem_i`=1. At 9.54 they take 0 with `fast_mem_i`=1, 2 with `spd_sel_i[0]`=1, and 4 otherwise.
- R8: Type code 11 is treated as a zero-wait cycle, so `ready_o` stays 1.
- R9: `cyc_start_i` is sampled only on the tick where `cpu_ce_o`=1, which is the last tick of a period. A strobe on any other tick has no effect.
- R10: A strobe while `ready_o` is 0 is ignored, so the cycle in progress keeps its original length.
- R11: A change of strap or speed bits in the middle of a period leaves that period at its old length. The new setting applies from the next period.
- R12: `cpu_clk_o` is high on the first tick of every period, and `cpu_ce_o` is high for exactly one tick per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xtal_slow_i | input | 1 | Crystal strap: 1 = low-rate crystal, 0 = double-rate crystal |
| spd_sel_i | input | 2 | Speed request: bit 1 = 9.54 MHz, bit 0 = 7.15 MHz |
| fast_mem_i | input | 1 | Zero-wait bus memory enable |
| cyc_start_i | input | 1 | Bus cycle start strobe |
| cyc_type_i | input | 2 | 00 I/O, 01 on-board memory, 10 bus memory, 11 zero-wait |
| cpu_clk_o | output | 1 | Processor clock waveform |
| cpu_ce_o | output | 1 | High on the last tick of each processor clock period |
| ready_o | output | 1 | Low while wait states are being inserted |

## Verification
Two cases are hard to reach. The first is a speed change that lands in the middle of a period. The bench finds a period boundary through `cpu_ce_o`, waits one tick and then switches from 6-tick to 3-tick timing. It checks that the current period still runs its full 6 ticks and that the following period is 3 ticks. The second is a start strobe that arrives while a long I/O cycle is waiting. The bench issues a second strobe on a boundary inside that cycle and checks that the total low time is unchanged.

// File: rtl/clkws_pkg.sv
package clkws_pkg;

  localparam int PH_W = 3;
  localparam int WS_W = 3;

  typedef enum logic [2:0] {
    M_LO_477 = 3'd0,
    M_LO_715 = 3'd1,
    M_HI_477 = 3'd2,
    M_HI_715 = 3'd3,
    M_HI_954 = 3'd4
  } clk_mode_e;

  typedef enum logic [1:0] {
    SP_477 = 2'd0,
    SP_715 = 2'd1,
    SP_954 = 2'd2
  } speed_e;

  typedef enum logic [1:0] {
    CT_IO   = 2'd0,
    CT_ONB  = 2'd1,
    CT_BUS  = 2'd2,
    CT_NONE = 2'd3
  } cyc_type_e;

  function automatic logic [PH_W-1:0] mode_period(clk_mode_e m);
    case (m)
      M_LO_477: mode_period = PH_W'(3);
      M_LO_715: mode_period = PH_W'(2);
      M_HI_477: mode_period = PH_W'(6);
      M_HI_715: mode_period = PH_W'(4);
      M_HI_954: mode_period = PH_W'(3);
      default:  mode_period = PH_W'(3);
    endcase
  endfunction

  function automatic logic [PH_W-1:0] mode_high(clk_mode_e m);
    case (m)
      M_HI_477: mode_high = PH_W'(2);
      M_HI_954: mode_high = PH_W'(2);
      default:  mode_high = PH_W'(1);
    endcase
  endfunction

  function automatic speed_e mode_speed(clk_mode_e m);
    case (m)
      M_LO_715, M_HI_715: mode_speed = SP_715;
      M_HI_954:           mode_speed = SP_954;
      default:            mode_speed = SP_477;
    endcase
  endfunction

  function automatic logic [WS_W-1:0] wait_count(speed_e sp, cyc_type_e ct,
                                                 logic mid, logic fast);
    wait_count = '0;
    if (ct == CT_IO) begin
      case (sp)
        SP_715:  wait_count = WS_W'(4);
        SP_954:  wait_count = WS_W'(6);
        default: wait_count = WS_W'(1);
      endcase
    end else if (ct == CT_BUS && !fast) begin
      case (sp)
        SP_715:  wait_count = WS_W'(2);
        SP_954:  wait_count = mid ? WS_W'(2) : WS_W'(4);
        default: wait_count = '0;
      endcase
    end
  endfunction

endpackage

// File: rtl/clkws_speed_sel.sv
module clkws_speed_sel
  import clkws_pkg::*;
(
  input  logic       xtal_slow_i,
  input  logic [1:0] spd_sel_i,
  output clk_mode_e  mode_o
);

  always_comb begin
    if (xtal_slow_i) begin
      // 9.54 is not reachable from the low-rate crystal: fall back to 7.15
      mode_o = (spd_sel_i != 2'b00) ? M_LO_715 : M_LO_477;
    end else if (spd_sel_i[1]) begin
      mode_o = M_HI_954;
    end else if (spd_sel_i[0]) begin
      mode_o = M_HI_715;
    end else begin
      mode_o = M_HI_477;
    end
  end

endmodule

// File: rtl/clkws_divider.sv
module clkws_divider
  import clkws_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_n,
  input  clk_mode_e req_mode_i,
  output logic      ce_o,
  output logic      cpu_clk_o,
  output clk_mode_e cur_mode_o
);

  logic [PH_W-1:0] ph_q, ph_d;
  clk_mode_e       mode_q, mode_d;
  logic            last;

  always_comb begin
    last   = (ph_q == mode_period(mode_q) - PH_W'(1));
    ph_d   = last ? '0 : ph_q + PH_W'(1);
    mode_d = last ? req_mode_i : mode_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      mode_q <= M_LO_477;
    end else begin
      ph_q   <= ph_d;
      mode_q <= mode_d;
    end
  end

  assign ce_o       = last;
  assign cpu_clk_o  = (ph_q < mode_high(mode_q));
  assign cur_mode_o = mode_q;

  // R11: the mode only moves across a period boundary
  a_r11_mode_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_n)
    !ce_o |=> $stable(cur_mode_o));

  // R12: the phase never runs past the period of the mode in force
  a_r12_phase_in_range: assert property (@(posedge clk_i) disable iff (!rst_n)
    ph_q < mode_period(mode_q));

endmodule

// File: rtl/clkws_wait_gen.sv
module clkws_wait_gen
  import clkws_pkg::*;
#(
  parameter int WAIT_W = WS_W
) (
  input  logic      clk_i,
  input  logic      rst_n,
  input  logic      ce_i,
  input  logic      start_i,
  input  cyc_type_e type_i,
  input  speed_e    speed_i,
  input  logic      mid_i,
  input  logic      fast_i,
  output logic      ready_o
);

  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              load_en, dec_en;

  always_comb begin
    dec_en  = ce_i && (cnt_q != '0);
    load_en = ce_i && (cnt_q == '0) && start_i;
    cnt_d   = cnt_q;
    if (dec_en) begin
      cnt_d = cnt_q - WAIT_W'(1);
    end else if (load_en) begin
      cnt_d = WAIT_W'(wait_count(speed_i, type_i, mid_i, fast_i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign ready_o = (cnt_q == '0);

  // R10: a wait in progress is not cut short between boundaries
  a_r10_hold_low: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!ready_o && !ce_i) |=> !ready_o);

  // R9: ready cannot fall off a boundary tick
  a_r9_start_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ready_o && !ce_i) |=> ready_o);

  // R6: on-board memory never waits
  a_r6_onboard_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ready_o && ce_i && start_i && type_i == CT_ONB) |=> ready_o);

endmodule

// File: rtl/cpu_clk_waitgen.sv
module cpu_clk_waitgen
  import clkws_pkg::*;
#(
  parameter int WAIT_W = WS_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       xtal_slow_i,
  input  logic [1:0] spd_sel_i,
  input  logic       fast_mem_i,
  input  logic       cyc_start_i,
  input  logic [1:0] cyc_type_i,
  output logic       cpu_clk_o,
  output logic       cpu_ce_o,
  output logic       ready_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n;
  clk_mode_e  req_mode, cur_mode;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  clkws_speed_sel u_sel (
    .xtal_slow_i (xtal_slow_i),
    .spd_sel_i   (spd_sel_i),
    .mode_o      (req_mode)
  );

  clkws_divider u_div (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .req_mode_i (req_mode),
    .ce_o       (cpu_ce_o),
    .cpu_clk_o  (cpu_clk_o),
    .cur_mode_o (cur_mode)
  );

  clkws_wait_gen #(.WAIT_W(WAIT_W)) u_wait (
    .clk_i   (clk_i),
    .rst_n   (rst_n),
    .ce_i    (cpu_ce_o),
    .start_i (cyc_start_i),
    .type_i  (cyc_type_e'(cyc_type_i)),
    .speed_i (mode_speed(req_mode)),
    .mid_i   (spd_sel_i[0]),
    .fast_i  (fast_mem_i),
    .ready_o (ready_o)
  );

  // R12: every period opens with the clock high
  a_r12_high_at_start: assert property (@(posedge clk_i) disable iff (!rst_n)
    cpu_ce_o |=> cpu_clk_o);

  // R4: the low-rate crystal never reaches the 9.54 mode
  a_r4_no_954_slow_xtal: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cpu_ce_o && xtal_slow_i) |=> (cur_mode != M_HI_954));

endmodule

// File: tb/tb_cpu_clk_waitgen.sv
module tb_cpu_clk_waitgen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       xtal_slow;
  logic [1:0] spd_sel;
  logic       fast_mem;
  logic       cyc_start;
  logic [1:0] cyc_type;
  logic       cpu_clk, cpu_ce, ready;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  cpu_clk_waitgen dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .xtal_slow_i (xtal_slow),
    .spd_sel_i   (spd_sel),
    .fast_mem_i  (fast_mem),
    .cyc_start_i (cyc_start),
    .cyc_type_i  (cyc_type),
    .cpu_clk_o   (cpu_clk),
    .cpu_ce_o    (cpu_ce),
    .ready_o     (ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(logic slow, logic [1:0] sel);
    if (slow) return (sel != 2'b00) ? 2 : 3;
    if (sel[1]) return 3;
    return sel[0] ? 4 : 6;
  endfunction

  function automatic int exp_high(logic slow, logic [1:0] sel);
    if (slow) return 1;
    if (sel[1]) return 2;
    return sel[0] ? 1 : 2;
  endfunction

  // 0 = 4.77, 1 = 7.15, 2 = 9.54
  function automatic int exp_speed(logic slow, logic [1:0] sel);
    if (slow) return (sel != 2'b00) ? 1 : 0;
    return sel[1] ? 2 : (sel[0] ? 1 : 0);
  endfunction

  function automatic int exp_waits(logic slow, logic [1:0] sel, logic fast, logic [1:0] ty);
    int sp = exp_speed(slow, sel);
    if (ty == 2'b00) return (sp == 0) ? 1 : (sp == 1) ? 4 : 6;
    if (ty == 2'b10) begin
      if (sp == 0 || fast) return 0;
      if (sp == 1) return 2;
      return sel[0] ? 2 : 4;
    end
    return 0;
  endfunction

  task automatic wait_ce();
    do @(negedge clk); while (!cpu_ce);
  endtask

  task automatic configure(input logic slow, input logic [1:0] sel, input logic fast);
    xtal_slow = slow; spd_sel = sel; fast_mem = fast;
    wait_ce(); wait_ce();
  endtask

  task automatic measure(output int n, output int h);
    wait_ce();
    n = 0; h = 0;
    do begin
      @(negedge clk);
      n++;
      if (cpu_clk) h++;
    end while (!cpu_ce);
  endtask

  task automatic run_cycle(input logic [1:0] ty, output int low);
    wait_ce();
    cyc_start = 1'b1; cyc_type = ty;
    @(negedge clk);
    cyc_start = 1'b0;
    low = 0;
    while (!ready) begin low++; @(negedge clk); end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; xtal_slow = 1'b1; spd_sel = 2'b00; fast_mem = 1'b0;
    cyc_start = 1'b0; cyc_type = 2'b00;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", ready, 1);
    chk("R1 ce in reset", cpu_ce, 0);
    chk("R1 clk in reset", cpu_clk, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after release", ready, 1);
  endtask

  task automatic t_periods(input logic slow, input string req);
    int n, h;
    for (int s = 0; s < 4; s++) begin
      configure(slow, 2'(s), 1'b0);
      measure(n, h);
      chk({req, " period"}, n, exp_period(slow, 2'(s)));
      chk({req, " high"}, h, exp_high(slow, 2'(s)));
    end
  endtask

  task automatic t_waits(input logic [1:0] ty, input string req);
    int low;
    for (int slow = 0; slow < 2; slow++)
      for (int s = 0; s < 4; s++)
        for (int f = 0; f < 2; f++) begin
          configure(1'(slow), 2'(s), 1'(f));
          run_cycle(ty, low);
          chk(req, low, exp_waits(1'(slow), 2'(s), 1'(f), ty) * exp_period(1'(slow), 2'(s)));
        end
  endtask

  task automatic t_off_boundary_start();
    int lows = 0;
    configure(1'b0, 2'b00, 1'b0);
    wait_ce();
    @(negedge clk);
    cyc_start = 1'b1; cyc_type = 2'b00;
    @(negedge clk);
    cyc_start = 1'b0;
    repeat (10) begin
      if (!ready) lows++;
      @(negedge clk);
    end
    chk("R9 strobe off boundary ignored", lows, 0);
  endtask

  task automatic t_busy_start();
    int low;
    configure(1'b0, 2'b10, 1'b0);
    wait_ce();
    cyc_start = 1'b1; cyc_type = 2'b00;
    @(negedge clk);
    cyc_start = 1'b0;
    low = 0;
    while (!ready) begin
      if (cpu_ce && low > 4) cyc_start = 1'b1;
      low++;
      @(negedge clk);
      cyc_start = 1'b0;
    end
    chk("R10 strobe during wait ignored", low, 18);
    repeat (8) @(negedge clk);
    chk("R10 no extra cycle", ready, 1);
  endtask

  task automatic t_mid_change();
    int n, h;
    configure(1'b0, 2'b00, 1'b0);
    wait_ce();
    @(negedge clk);
    spd_sel = 2'b10;
    n = 1;
    while (!cpu_ce) begin @(negedge clk); n++; end
    chk("R11 current period keeps length", n, 6);
    n = 0; h = 0;
    do begin @(negedge clk); n++; if (cpu_clk) h++; end while (!cpu_ce);
    chk("R11 next period new length", n, 3);
    chk("R11 next period new high", h, 2);
  endtask

  task automatic t_ce_once();
    int ces = 0;
    configure(1'b0, 2'b00, 1'b0);
    wait_ce();
    repeat (12) begin @(negedge clk); if (cpu_ce) ces++; end
    chk("R12 one ce per period", ces, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_periods(1'b1, "R2/R4 slow crystal");
    t_periods(1'b0, "R3 fast crystal");
    t_waits(2'b00, "R5 io waits");
    t_waits(2'b01, "R6 onboard waits");
    t_waits(2'b10, "R7 bus waits");
    t_waits(2'b11, "R8 type 11 waits");
    t_off_boundary_start();
    t_busy_start();
    t_mid_change();
    t_ce_once();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule